// File: doc/BRIEF.md
# Two-Bank Prefetch Queue

This block is a single-clock first-in first-out queue with zero read latency. Entries that are waiting deep in the queue sit in two alternating storage banks. Even-numbered entries go to one bank and odd-numbered entries go to the other. The oldest two entries are held in a pair of staging registers on the output side, so the head entry is always on `rd_data` without a memory access.

A read moves the output selector to the other staging register. The register just emptied is then refilled from the banks in the same cycle. When the banks hold nothing and a staging register is free, a write goes straight into that register. This means a word written into an empty queue is visible on the next cycle.

The queue holds `2*BANK_DEPTH + 2` entries. A producer writes with `wr_en` and `wr_data`. A consumer takes the word on `rd_data` by raising `rd_en` while `empty` is low.

Top module: `pingpong_fifo`

## Requirements
- R1: After reset, `empty` is 1 and `full` is 0.
- R2: Words leave on `rd_data` in exactly the order in which they were accepted, under any mix of reads and writes.
- R3: Starting from empty, with writes only, `full` rises exactly after the `2*BANK_DEPTH+2`-th accepted write and not earlier.
- R4: A write into an empty queue sets `empty` to 0 on the next cycle, with the written word already on `rd_data`.
- R5: While `empty` is 0, `rd_data` always carries the oldest word. After an accepted read, the next word is on `rd_data` in the following cycle, so back-to-back reads on every cycle drain the queue in order.
- R6: A write while `full` is 1 is dropped. No later read returns that word, and the head word and `full` stay unchanged.
- R7: A read while `empty` is 1 is dropped. `empty` stays 1 and no word is lost.
- R8: When the queue is neither empty nor full, a read and a write in the same cycle both take effect, and the occupancy stays the same.
- R9: `full` is judged before a read in the same cycle. A write together with a read while `full` is 1 is dropped, the read is accepted, and `full` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to enqueue |
| rd_en | input | 1 | Read request; consumes the word on rd_data |
| rd_data | output | DW | Current head word, valid while empty is 0 |
| empty | output | 1 | No word is held |
| full | output | 1 | Banks and both staging registers are occupied |

## Verification
The two functions that can fall in the same cycle are an enqueue and a dequeue. A dequeue can in turn trigger a staging refill from one bank while the enqueue lands in a bank or in the other staging register. The bench provokes this with random concurrent requests at every fill level, including the edges: a single entry held (bypass during a read), banks exactly empty, and full with a read and a write together. After every clock, a behavioural queue model judges the flags and the head word against the outputs.

// File: rtl/pingpong_fifo.sv
module pingpong_fifo #(
  parameter int DW = 8,
  parameter int BANK_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  localparam int BCAP = 2 * BANK_DEPTH;
  localparam int PW   = $clog2(BCAP);
  localparam int NW   = $clog2(BCAP + 1);

  logic [DW-1:0] bank [2][BANK_DEPTH];
  logic [DW-1:0] stg  [2];
  logic [1:0]    sv;
  logic          sel;
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] bc;

  assign rd_data = stg[sel];
  assign empty   = !sv[sel];
  assign full    = (bc == NW'(BCAP)) && (&sv);

  wire do_rd  = rd_en && !empty;
  wire do_wr  = wr_en && !full;
  wire refill = do_rd && (bc != '0);
  wire hsel   = do_rd ? ~sel : sel;

  logic [1:0] sv_a;
  always_comb begin
    sv_a = sv;
    if (do_rd) sv_a[sel] = refill;
  end

  wire to_bank  = do_wr && (&sv_a);
  wire to_stage = do_wr && !(&sv_a);
  wire tslot    = sv_a[hsel] ? ~hsel : hsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sv  <= '0;
      sel <= 1'b0;
      wp  <= '0;
      rp  <= '0;
      bc  <= '0;
    end else begin
      sel <= hsel;
      sv  <= sv_a;
      if (to_stage) sv[tslot] <= 1'b1;
      if (refill)  rp <= rp + 1'b1;
      if (to_bank) wp <= wp + 1'b1;
      bc <= bc + NW'(to_bank) - NW'(refill);
    end
  end

  always_ff @(posedge clk) begin
    if (refill)   stg[sel]   <= bank[rp[0]][rp[PW-1:1]];
    if (to_stage) stg[tslot] <= wr_data;
    if (to_bank)  bank[wp[0]][wp[PW-1:1]] <= wr_data;
  end
endmodule

module pingpong_fifo_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          empty,
  input logic          full
);
  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  assert_bypass_head_R4: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_en) |=> (!empty && rd_data == $past(wr_data)));

  assert_head_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!empty && !rd_en) |=> (!empty && $stable(rd_data)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> (full && $stable(rd_data)));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> empty);

  assert_full_read_frees_R9: assert property (@(posedge clk) disable iff (rst)
    (full && rd_en) |=> !full);
endmodule

bind pingpong_fifo pingpong_fifo_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full)
);

// File: tb/pingpong_fifo_test.sv
module pingpong_fifo_test;
  localparam int DW  = 8;
  localparam int BD  = 4;
  localparam int CAP = 2 * BD + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic empty, full;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] q[$];

  always #2 clk = ~clk;

  pingpong_fifo #(.DW(DW), .BANK_DEPTH(BD)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "empty", int'(empty), int'(q.size() == 0));
    chk(tag, "full", int'(full), int'(q.size() == CAP));
    if (q.size() != 0) chk(tag, "rd_data", int'(rd_data), int'(q[0]));
  endtask

  task automatic step(input logic w, input logic r, input logic [DW-1:0] d, input string tag);
    int sz;
    wr_en = w; rd_en = r; wr_data = d;
    sz = q.size();
    if (r && sz > 0) void'(q.pop_front());
    if (w && sz < CAP) q.push_back(d);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);

    step(0, 1, 8'h00, "R7");
    step(0, 1, 8'h00, "R7");
    step(1, 0, 8'hA5, "R4");
    chk("R4", "bypass word", int'(rd_data), 8'hA5);
    step(1, 1, 8'h5A, "R4");
    step(0, 1, 8'h00, "R7");
    step(0, 1, 8'h00, "R7");

    for (int i = 0; i < CAP; i++) step(1, 0, 8'(8'h10 + i), "R3");
    chk("R3", "full after capacity", int'(full), 1);
    step(1, 0, 8'hEE, "R6");
    step(1, 0, 8'hED, "R6");
    step(1, 1, 8'hEF, "R9");
    chk("R9", "full after read", int'(full), 0);
    step(1, 1, 8'h40, "R8");
    step(1, 1, 8'h41, "R8");
    for (int i = 0; i < CAP + 2; i++) step(0, 1, 8'h00, "R5");

    for (int i = 0; i < 4; i++) step(1, 0, 8'(8'h60 + i), "R8");
    for (int i = 0; i < 20; i++) step(1, 1, 8'(8'h70 + i), "R8");
    for (int i = 0; i < 6; i++) step(0, 1, 8'h00, "R5");

    for (int i = 0; i < 3000; i++) begin
      int mode;
      logic w, r;
      mode = i / 500;
      w = ($urandom % 4) < ((mode % 2 == 0) ? 3 : 1);
      r = ($urandom % 4) < ((mode % 2 == 0) ? 1 : 3);
      if (mode >= 4) begin w = $urandom % 2; r = $urandom % 2; end
      step(w, r, 8'($urandom), "R2");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule